// File: doc/BRIEF.md
# Receive Idle Deletion and Entry Packing

This block sits on the write side of a receive clock-compensation FIFO for a 10GBASE-R style link. Each cycle it accepts a pair of 36-bit words (a lower and an upper word, each 32 data bits plus 4 per-byte control flags). When the FIFO reports that it is filling up, the block removes Idle words and repeated ordered-set words so that the slower read side can catch up.

The words that survive are packed into full two-word FIFO entries. If only one word of a pair is removed, one word is held over and joined with the next surviving word. The block drives the FIFO write enable and places a deletion marker in bit 8 of the entry control field. It also drives a deletion status pulse straight to its port, outside the FIFO path.

Top module: `idle_deleter`

## Requirements
- R1: While `blockLock` is low, nothing is written and nothing is deleted. Any held-over word is discarded. The remembered previous upper word is cleared, so it counts as neither Terminate nor ordered set.
- R2: While `fifoPfull` is low, no word is deleted. Every word of every locked cycle reaches the FIFO in arrival order, lower word before upper word.
- R3: A word is Idle when its 4 control bits are all set and every byte equals 0x07. The current lower word is deleted when three conditions hold: it is Idle, the previous cycle's upper word is not Terminate, and the current upper word is not Terminate.
- R4: The current upper word is deleted when it is Idle and the current lower word is not Terminate.
- R5: A word is an ordered set when control bit 0 is set and byte 0 (bits 7:0) equals 0x9C. The lower word is deleted when it and the previous upper word are both ordered sets. The upper word is deleted when it and the current lower word are both ordered sets.
- R6: A word is Terminate when any byte whose control bit is set equals 0xFD. Terminate words are never deleted, and they block the deletions named in R3 and R4.
- R7: Surviving words are packed two per entry, in order. The first of the pair goes to `wrData[31:0]` / `wrCtrl[3:0]` and the second to `wrData[63:32]` / `wrCtrl[7:4]`. At most one word is held over to a later cycle.
- R8: `wrEn` is high exactly in the cycles where at least two surviving words are available. After two deletions the write enable therefore drops for one cycle.
- R9: Each time the running count of deleted words completes another pair, `wrCtrl[8]` is set on the next entry written after that cycle. It is 0 on all other entries.
- R10: `delPulse` is high for one cycle, the cycle after any input cycle in which at least one word was deleted.
- R11: Outputs are registered and appear one clock after the inputs that produce them. A synchronous active-high `rst` clears the outputs, the held-over word, the word history and the deletion counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous active-high reset |
| blockLock | input | 1 | Block synchronizer has lock |
| fifoPfull | input | 1 | FIFO partially-full level, enables deletion |
| inLo | input | 36 | Lower word: control flags [35:32], data [31:0] |
| inUp | input | 36 | Upper word: control flags [35:32], data [31:0] |
| wrEn | output | 1 | FIFO write enable |
| wrData | output | 64 | Entry data, first word in [31:0] |
| wrCtrl | output | 9 | Entry control flags [7:0], deletion marker [8] |
| delPulse | output | 1 | Deletion status pulse |

## Verification
A wrong held-over word or a lost pending flag shows up in the very next written entry. The data comes out misordered, duplicated or missing against the scoreboard, and every entry after it stays shifted by one word until a lock drop flushes the state. A corrupted previous-upper-word history changes the lower-word decision one cycle later. It shows as a wrong write-enable pattern or a missing `delPulse` in that cycle. A bad deletion parity moves the `wrCtrl[8]` marker to the wrong entry, which the scoreboard sees at the first marked write.

// File: rtl/idle_del_pkg.sv
package idle_del_pkg;
  localparam int BYTES   = 4;
  localparam int DATA_W  = BYTES * 8;
  localparam int WORD_W  = DATA_W + BYTES;
  localparam logic [7:0] IDLE_CODE = 8'h07;
  localparam logic [7:0] TERM_CODE = 8'hFD;
  localparam logic [7:0] SEQ_CODE  = 8'h9C;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic keepLo;
    logic keepUp;
    logic flush;
    logic pairDone;
    logic anyDel;
  } strobe_t;

  function automatic logic isIdle(word_t w);
    logic r;
    r = 1'b1;
    for (int i = 0; i < BYTES; i++) begin
      if (!w[DATA_W+i] || (w[8*i +: 8] != IDLE_CODE)) r = 1'b0;
    end
    return r;
  endfunction

  function automatic logic isTerm(word_t w);
    logic r;
    r = 1'b0;
    for (int i = 0; i < BYTES; i++) begin
      if (w[DATA_W+i] && (w[8*i +: 8] == TERM_CODE)) r = 1'b1;
    end
    return r;
  endfunction

  function automatic logic isSeq(word_t w);
    return w[DATA_W] && (w[7:0] == SEQ_CODE);
  endfunction
endpackage

// File: rtl/idle_del_ctrl.sv
module idle_del_ctrl
  import idle_del_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    blockLock,
  input  logic    fifoPfull,
  input  word_t   inLo,
  input  word_t   inUp,
  output strobe_t st,
  output logic    delPulse
);
  word_t      prevUp;
  logic       delParity;
  logic       delEn, delLo, delUp;
  logic [1:0] delSum;

  always_comb begin
    delEn = blockLock && fifoPfull;
    delLo = delEn && ((isIdle(inLo) && !isTerm(prevUp) && !isTerm(inUp)) ||
                      (isSeq(inLo) && isSeq(prevUp)));
    delUp = delEn && ((isIdle(inUp) && !isTerm(inLo)) ||
                      (isSeq(inUp) && isSeq(inLo)));
    delSum = {1'b0, delParity} + {1'b0, delLo} + {1'b0, delUp};
    st.keepLo   = blockLock && !delLo;
    st.keepUp   = blockLock && !delUp;
    st.flush    = !blockLock;
    st.pairDone = delSum[1];
    st.anyDel   = delLo || delUp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevUp    <= '0;
      delParity <= 1'b0;
      delPulse  <= 1'b0;
    end else begin
      prevUp    <= blockLock ? inUp : '0;
      delParity <= delSum[0];
      delPulse  <= st.anyDel;
    end
  end

  // R10
  del_needs_pfull_chk: assert property (@(posedge clk) disable iff (rst)
    delPulse |-> $past(fifoPfull && blockLock));
  // R9
  parity_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(delLo || delUp) |=> $stable(delParity));
  // R1
  lock_hist_chk: assert property (@(posedge clk) disable iff (rst)
    !blockLock |=> (prevUp == '0));
endmodule

// File: rtl/idle_del_path.sv
module idle_del_path
  import idle_del_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  word_t                 inLo,
  input  word_t                 inUp,
  input  strobe_t               st,
  output logic                  wrEn,
  output logic [2*DATA_W-1:0]   wrData,
  output logic [2*BYTES:0]      wrCtrl
);
  localparam int SLOTS = 3;

  word_t      pendWord;
  logic       pendValid;
  logic       markNext;
  word_t      slot [SLOTS];
  logic [1:0] cnt;
  logic       doWrite;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) slot[i] = '0;
    cnt = 2'd0;
    if (pendValid) begin
      slot[cnt] = pendWord;
      cnt = cnt + 2'd1;
    end
    if (st.keepLo) begin
      slot[cnt] = inLo;
      cnt = cnt + 2'd1;
    end
    if (st.keepUp) begin
      slot[cnt] = inUp;
      cnt = cnt + 2'd1;
    end
    doWrite = cnt[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendWord  <= '0;
      pendValid <= 1'b0;
      markNext  <= 1'b0;
      wrEn      <= 1'b0;
      wrData    <= '0;
      wrCtrl    <= '0;
    end else begin
      wrEn     <= doWrite;
      markNext <= st.pairDone || (markNext && !doWrite);
      if (doWrite) begin
        wrData <= {slot[1][DATA_W-1:0], slot[0][DATA_W-1:0]};
        wrCtrl <= {markNext, slot[1][WORD_W-1:DATA_W], slot[0][WORD_W-1:DATA_W]};
      end else begin
        wrData <= '0;
        wrCtrl <= '0;
      end
      if (st.flush) begin
        pendValid <= 1'b0;
        pendWord  <= '0;
      end else if (doWrite) begin
        pendValid <= cnt[0];
        pendWord  <= slot[2];
      end else begin
        pendValid <= cnt[0];
        pendWord  <= slot[0];
      end
    end
  end

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pendValid && !st.keepLo && !st.keepUp && !st.flush) |=> (pendValid && $stable(pendWord)));
  // R8
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(pendValid || st.keepLo || st.keepUp) |=> !wrEn);
  // R9
  mark_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    wrCtrl[2*BYTES] |-> wrEn);
endmodule

// File: rtl/idle_deleter.sv
module idle_deleter
  import idle_del_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                blockLock,
  input  logic                fifoPfull,
  input  logic [WORD_W-1:0]   inLo,
  input  logic [WORD_W-1:0]   inUp,
  output logic                wrEn,
  output logic [2*DATA_W-1:0] wrData,
  output logic [2*BYTES:0]    wrCtrl,
  output logic                delPulse
);
  strobe_t st;

  idle_del_ctrl u_ctrl (
    .clk(clk), .rst(rst), .blockLock(blockLock), .fifoPfull(fifoPfull),
    .inLo(inLo), .inUp(inUp), .st(st), .delPulse(delPulse)
  );

  idle_del_path u_path (
    .clk(clk), .rst(rst), .inLo(inLo), .inUp(inUp), .st(st),
    .wrEn(wrEn), .wrData(wrData), .wrCtrl(wrCtrl)
  );
endmodule

// File: tb/idle_deleter_tb.sv
module idle_deleter_tb;
  typedef logic [35:0] w36_t;
  typedef struct {
    bit          wr;
    bit          pulse;
    logic [63:0] d;
    logic [8:0]  c;
    string       tag;
  } exp_t;

  logic clk = 0, rst = 1, blockLock = 0, fifoPfull = 0;
  w36_t inLo = '0, inUp = '0;
  logic wrEn, delPulse;
  logic [63:0] wrData;
  logic [8:0]  wrCtrl;

  int checks = 0, errors = 0;
  exp_t expQ[$];

  w36_t mPrev = '0;
  w36_t mHeld[$];
  int   mParity = 0;
  bit   mMark = 0;

  localparam w36_t IDL  = {4'hF, 32'h07070707};
  localparam w36_t TLO  = {4'hF, 32'h070707FD};
  localparam w36_t TBY1 = {4'hE, 32'h0707FDAA};
  localparam w36_t OS1  = {4'h1, 32'h0000009C};
  localparam w36_t OS2  = {4'h1, 32'h0000029C};

  always #10 clk = ~clk;

  idle_deleter u_dut (
    .clk(clk), .rst(rst), .blockLock(blockLock), .fifoPfull(fifoPfull),
    .inLo(inLo), .inUp(inUp), .wrEn(wrEn), .wrData(wrData),
    .wrCtrl(wrCtrl), .delPulse(delPulse)
  );

  function automatic bit tIdle(w36_t w);
    return w[35:32] == 4'hF && w[31:0] == 32'h07070707;
  endfunction
  function automatic bit tTerm(w36_t w);
    for (int b = 0; b < 4; b++)
      if (w[32+b] && w[8*b +: 8] == 8'hFD) return 1;
    return 0;
  endfunction
  function automatic bit tOs(w36_t w);
    return w[32] && w[7:0] == 8'h9C;
  endfunction
  function automatic w36_t dw(int n);
    return {4'h0, 32'hD0000000 + n[31:0]};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic step(w36_t lo, w36_t up, bit lock, bit pf, string tag);
    exp_t e;
    bit dl, du;
    int n;
    w36_t a, b;
    inLo = lo; inUp = up; blockLock = lock; fifoPfull = pf;
    dl = lock && pf && ((tIdle(lo) && !tTerm(mPrev) && !tTerm(up)) || (tOs(lo) && tOs(mPrev)));
    du = lock && pf && ((tIdle(up) && !tTerm(lo)) || (tOs(up) && tOs(lo)));
    if (lock && !dl) mHeld.push_back(lo);
    if (lock && !du) mHeld.push_back(up);
    e.wr = 0; e.d = '0; e.c = '0; e.tag = tag;
    if (mHeld.size() >= 2) begin
      a = mHeld.pop_front();
      b = mHeld.pop_front();
      e.wr = 1;
      e.d = {b[31:0], a[31:0]};
      e.c = {mMark, b[35:32], a[35:32]};
    end
    e.pulse = dl || du;
    n = int'(dl) + int'(du);
    mMark = ((mParity + n) >= 2) || (mMark && !e.wr);
    mParity = (mParity + n) % 2;
    if (!lock) mHeld.delete();
    mPrev = lock ? up : '0;
    @(posedge clk);
    #2;
    expQ.push_back(e);
  endtask

  // monitor: one expected item per clock after the driver starts
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(wrEn === e.wr, e.tag, "wrEn (R8)", 64'(wrEn), 64'(e.wr));
      check(delPulse === e.pulse, e.tag, "delPulse (R10)", 64'(delPulse), 64'(e.pulse));
      if (e.wr) begin
        check(wrData === e.d, e.tag, "wrData (R7)", wrData, e.d);
        check(wrCtrl === e.c, e.tag, "wrCtrl (R9)", 64'(wrCtrl), 64'(e.c));
      end
    end
  end

  bit done = 0;
  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    w36_t pick [6];
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    // R11 reset state
    check(wrEn === 0 && delPulse === 0 && wrCtrl === '0, "R11", "reset outputs",
          {wrEn, delPulse, wrCtrl}, 64'd0);
    @(posedge clk); #2;
    // R1: no lock, nothing written
    for (int i = 0; i < 4; i++) step(dw(i), IDL, 0, 1, "R1");
    // R2: pfull low, pass-through including Idles
    step(dw(1), dw(2), 1, 0, "R2");
    step(IDL, IDL, 1, 0, "R2");
    step(OS1, OS2, 1, 0, "R2");
    // R3 / R7: lower Idle deleted, single holdover
    step(IDL, dw(3), 1, 1, "R3");
    step(dw(4), dw(5), 1, 1, "R7");
    // R4 / R8 / R9 / R10: upper Idle deleted completes a pair
    step(dw(6), IDL, 1, 1, "R4");
    step(IDL, IDL, 1, 1, "R8");
    step(dw(7), dw(8), 1, 1, "R9");
    step(dw(9), dw(10), 1, 1, "R9");
    // R6: previous upper Terminate blocks lower Idle
    step(dw(11), TBY1, 1, 1, "R6");
    step(IDL, dw(12), 1, 1, "R6");
    // R6: current upper Terminate blocks lower Idle
    step(IDL, TLO, 1, 1, "R6");
    // R6: lower Terminate blocks upper Idle
    step(TLO, IDL, 1, 1, "R6");
    step(dw(13), dw(14), 1, 1, "R6");
    // R5: ordered sets
    step(dw(15), OS1, 1, 1, "R5");
    step(OS2, OS1, 1, 1, "R5");
    step(OS1, dw(16), 1, 1, "R5");
    step(dw(17), dw(18), 1, 1, "R5");
    // R1: lock loss discards held word
    step(IDL, dw(19), 1, 1, "R1");
    step(dw(20), dw(21), 0, 1, "R1");
    step(IDL, dw(22), 1, 1, "R1");
    step(dw(23), dw(24), 1, 0, "R1");
    // R7 mixed patterns
    pick[0] = IDL; pick[1] = TLO; pick[2] = OS1; pick[3] = OS2; pick[4] = TBY1; pick[5] = '0;
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      w36_t lo, up;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lo = (lfsr[2:0] < 6) ? pick[lfsr[2:0]] : dw(100 + i);
      up = (lfsr[5:3] < 6) ? pick[lfsr[5:3]] : dw(600 + i);
      if (lfsr[6]) lo = dw(1000 + i);
      step(lo, up, lfsr[15:11] != 0, lfsr[9] | lfsr[8], "R7");
    end
    step(dw(1), dw(2), 1, 0, "R2");
    step(dw(3), dw(4), 1, 0, "R2");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule